// File: doc/BRIEF.md
# Replica-Row Failure Voting Comparator

This block turns the raw failure flags of a bank of replica storage rows into a single decision used by a standby supply loop. Every row carries two groups of redundant detectors, one group watching a row that holds a one and one group watching a row that holds a zero. Each group is reduced by a majority vote, so one misbehaving detector cannot mark a row as failed. A row fails when either of its two votes says so.

The per-row failure bits form a status word. Rows that fail at the highest supply voltage sit in the low-order bits, so a status word grows like a thermometer as the supply drops. The block compares this word numerically against a stored threshold word and raises the failure output only when the status is strictly above the threshold. Software or a sequencer can load the threshold at any time. An evaluate enable gates the whole result, and both outputs are registered.

Top module: `canary_vote_cmp`

## Requirements
- R1: Detector k of row r is bit r*3+k of `flag_one_i` and of `flag_zero_i`, and row r drives bit r of `status_o`, so row 0 is the least significant bit.
- R2: A row's one-group votes failure when two or three of its three `flag_one_i` bits are 1; a single set bit does not fail the row.
- R3: A row's zero-group votes in the same way on `flag_zero_i`, and the row fails when either group votes failure.
- R4: `fail_o` is 1 only when `status_o`, read as an unsigned number, is strictly greater than the stored threshold; an equal status keeps it 0 (threshold 0x0F: status 0x1F fails, status 0x0F does not).
- R5: While `eval_i` is 0 at a clock edge, `status_o` and `fail_o` are 0 after that edge, whatever the flags are.
- R6: `status_o` and `fail_o` are registered: they reflect the flags, `eval_i` and the threshold sampled at the previous rising edge of `clk_i`.
- R7: With `thr_we_i` high at an edge the threshold is loaded from `thr_wdata_i`; the comparison at that same edge still uses the old value, the new one applies from the next edge on, and the value holds while `thr_we_i` is low.
- R8: While `rst_ni` is low, `status_o` and `fail_o` are 0 and the threshold is all ones, so no status can fail until a threshold is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate enable; low forces both results to zero |
| flag_one_i | input | 24 | Raw detector flags of the one-holding rows, three per row |
| flag_zero_i | input | 24 | Raw detector flags of the zero-holding rows, three per row |
| thr_we_i | input | 1 | Threshold write strobe |
| thr_wdata_i | input | 8 | Threshold value to load |
| status_o | output | 8 | Registered per-row failure word, row 0 in bit 0 |
| fail_o | output | 1 | Registered result of status above threshold |

## Verification
Both results are due one rising edge after the inputs they depend on, and a threshold write is due one edge later than that, since the compare at the write edge still sees the old value. The bench drives every input on the falling edge, computes the expected status and failure from those inputs and its own copy of the threshold before the rising edge, updates that copy only after the edge, and compares on the next falling edge. Directed cycles cover single and double detector hits in each group, the equal and one-above threshold cases, the gated state and a write that shares a cycle with a status change; a random phase follows.

// File: rtl/canary_vote_pkg.sv
package canary_vote_pkg;

  localparam int unsigned ROWS_DEF  = 8;
  localparam int unsigned VOTES_DEF = 3;

  // votes needed for a strict majority
  function automatic int unsigned need_votes(input int unsigned votes);
    return votes / 2 + 1;
  endfunction

endpackage

// File: rtl/maj_vote.sv
module maj_vote #(
  parameter int unsigned VOTES = canary_vote_pkg::VOTES_DEF
) (
  input  logic [VOTES-1:0] flag_i,
  output logic             vote_o
);
  localparam int unsigned NEED = canary_vote_pkg::need_votes(VOTES);

  always_comb begin
    vote_o = ($countones(flag_i) >= NEED);
  end
endmodule

// File: rtl/row_fail.sv
module row_fail #(
  parameter int unsigned VOTES = canary_vote_pkg::VOTES_DEF
) (
  input  logic [VOTES-1:0] one_i,
  input  logic [VOTES-1:0] zero_i,
  output logic             fail_o
);
  logic vote_one, vote_zero;

  maj_vote #(.VOTES(VOTES)) u_one  (.flag_i(one_i),  .vote_o(vote_one));
  maj_vote #(.VOTES(VOTES)) u_zero (.flag_i(zero_i), .vote_o(vote_zero));

  assign fail_o = vote_one | vote_zero;
endmodule

// File: rtl/thr_reg.sv
module thr_reg #(
  parameter int unsigned W = canary_vote_pkg::ROWS_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_o <= '1;
    else if (we_i) thr_o <= wdata_i;
  end
endmodule

// File: rtl/canary_vote_cmp.sv
module canary_vote_cmp #(
  parameter int unsigned ROWS  = canary_vote_pkg::ROWS_DEF,
  parameter int unsigned VOTES = canary_vote_pkg::VOTES_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  eval_i,
  input  logic [ROWS*VOTES-1:0] flag_one_i,
  input  logic [ROWS*VOTES-1:0] flag_zero_i,
  input  logic                  thr_we_i,
  input  logic [ROWS-1:0]       thr_wdata_i,
  output logic [ROWS-1:0]       status_o,
  output logic                  fail_o
);
  localparam int unsigned FW = ROWS * VOTES;

  logic [ROWS-1:0] row_d;
  logic [ROWS-1:0] thr_q;
  logic            above;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    row_fail #(.VOTES(VOTES)) u_row (
      .one_i  (flag_one_i [r*VOTES +: VOTES]),
      .zero_i (flag_zero_i[r*VOTES +: VOTES]),
      .fail_o (row_d[r])
    );
  end

  thr_reg #(.W(ROWS)) u_thr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (thr_we_i),
    .wdata_i (thr_wdata_i),
    .thr_o   (thr_q)
  );

  // unsigned compare, strict
  assign above = (row_d > thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      fail_o   <= 1'b0;
    end else if (!eval_i) begin
      status_o <= '0;
      fail_o   <= 1'b0;
    end else begin
      status_o <= row_d;
      fail_o   <= above;
    end
  end

  logic unused_fw;
  assign unused_fw = (FW == 0);
endmodule

// File: rtl/canary_vote_cmp_chk.sv
module canary_vote_cmp_chk #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned VOTES = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  eval_i,
  input logic [ROWS*VOTES-1:0] flag_one_i,
  input logic [ROWS*VOTES-1:0] flag_zero_i,
  input logic                  thr_we_i,
  input logic [ROWS-1:0]       thr_wdata_i,
  input logic [ROWS-1:0]       thr_q,
  input logic [ROWS-1:0]       status_o,
  input logic                  fail_o
);
  localparam int NEED = VOTES / 2 + 1;

  AST_GATED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> (status_o == '0 && !fail_o)); // R5

  AST_FAIL_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (status_o > $past(thr_q))); // R4

  AST_EQ_NO_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && $past(eval_i) && status_o <= $past(thr_q)) |-> !fail_o); // R4

  AST_THR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_we_i |=> (thr_q == $past(thr_wdata_i))); // R7

  AST_THR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thr_we_i |=> $stable(thr_q)); // R7

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    AST_ROW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eval_i && ($countones(flag_one_i[r*VOTES +: VOTES]) >= NEED ||
                  $countones(flag_zero_i[r*VOTES +: VOTES]) >= NEED))
      |=> status_o[r]); // R3

    AST_ROW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(flag_one_i[r*VOTES +: VOTES]) < NEED &&
       $countones(flag_zero_i[r*VOTES +: VOTES]) < NEED)
      |=> !status_o[r]); // R2
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_ZERO: assert (status_o == '0 && !fail_o); // R8
    end
  end
endmodule

bind canary_vote_cmp canary_vote_cmp_chk #(.ROWS(ROWS), .VOTES(VOTES)) u_chk (.*);

// File: tb/sim_canary_vote_cmp.sv
`timescale 1ns/1ps
module sim_canary_vote_cmp;
  localparam int ROWS = 8;
  localparam int VOTES = 3;
  localparam int FW = ROWS * VOTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eval = 1'b0;
  logic [FW-1:0] f_one = '0;
  logic [FW-1:0] f_zero = '0;
  logic thr_we = 1'b0;
  logic [ROWS-1:0] thr_wd = '0;
  logic [ROWS-1:0] status;
  logic fail;

  always #2.5 clk = ~clk;

  canary_vote_cmp u0 (
    .clk_i(clk), .rst_ni(rst_n), .eval_i(eval),
    .flag_one_i(f_one), .flag_zero_i(f_zero),
    .thr_we_i(thr_we), .thr_wdata_i(thr_wd),
    .status_o(status), .fail_o(fail)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [ROWS-1:0] m_thr;

  function automatic logic [FW-1:0] grp(int row, logic [VOTES-1:0] bits);
    logic [FW-1:0] v = '0;
    v[row*VOTES +: VOTES] = bits;
    return v;
  endfunction

  function automatic logic [ROWS-1:0] ref_status(logic e, logic [FW-1:0] a, logic [FW-1:0] b);
    logic [ROWS-1:0] s = '0;
    for (int r = 0; r < ROWS; r++) begin
      int ca = 0;
      int cb = 0;
      for (int k = 0; k < VOTES; k++) begin
        ca += a[r*VOTES+k];
        cb += b[r*VOTES+k];
      end
      s[r] = e && (ca >= 2 || cb >= 2);
    end
    return s;
  endfunction

  task automatic check(string req, logic [ROWS-1:0] es, logic ef);
    checks++;
    if (status !== es) begin
      errors++;
      $display("FAIL %s status actual=%h expected=%h", req, status, es);
    end
    checks++;
    if (fail !== ef) begin
      errors++;
      $display("FAIL %s fail actual=%b expected=%b", req, fail, ef);
    end
  endtask

  // inputs already set after a falling edge; check at the next falling edge
  task automatic step(string req);
    logic [ROWS-1:0] es;
    logic ef;
    es = ref_status(eval, f_one, f_zero);
    ef = eval && (es > m_thr);
    @(posedge clk);
    if (thr_we) m_thr = thr_wd;
    @(negedge clk);
    check(req, es, ef);
    thr_we = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_thr = '1;
    repeat (3) @(negedge clk);
    check("R8 reset", '0, 1'b0);
    rst_n = 1'b1;

    // R8: reset threshold all ones, full status does not fail
    eval = 1'b1; f_one = '1; f_zero = '1;
    step("R8 thr_reset");
    // R2: one detector per row never fails a row
    f_one = '0; f_zero = '0;
    for (int r = 0; r < ROWS; r++) begin
      f_one  |= grp(r, 3'b001 << (r % 3));
      f_zero |= grp(r, 3'b100 >> (r % 3));
    end
    step("R2 single_hit");
    // R7: write threshold 0x0F, compare at same edge uses old value
    thr_we = 1'b1; thr_wd = 8'h0F;
    f_one = grp(0, 3'b011) | grp(1, 3'b110) | grp(2, 3'b101) | grp(3, 3'b111) | grp(4, 3'b011);
    f_zero = '0;
    step("R7 write_same_edge");
    // R4: 0x1F above 0x0F
    step("R4 above");
    // R4: equal
    f_one = grp(0, 3'b011) | grp(1, 3'b110) | grp(2, 3'b101) | grp(3, 3'b111);
    step("R4 equal");
    // R2 / R1: row 3 one-group only, bit 3
    f_one = grp(3, 3'b101);
    step("R1 row3_bit");
    // R3: row 5 zero-group majority, one-group single hit
    f_one = grp(5, 3'b010); f_zero = grp(5, 3'b110);
    step("R3 zero_group");
    // R3: both groups on row 7
    f_one = grp(7, 3'b111); f_zero = grp(7, 3'b011);
    step("R3 both_groups");
    // R5: gated
    eval = 1'b0; f_one = '1; f_zero = '1;
    step("R5 gated");
    step("R5 gated_hold");
    // R6: enable again, result one edge later
    eval = 1'b1; f_one = grp(6, 3'b011); f_zero = '0;
    step("R6 latency");
    // R7: threshold holds without write
    thr_wd = 8'h00;
    f_one = grp(4, 3'b011);
    step("R7 hold");
    // R7: new threshold 0x00, any failure then fails
    thr_we = 1'b1; thr_wd = 8'h00;
    f_one = grp(0, 3'b110);
    step("R7 write_zero");
    step("R7 applied");
    // random
    for (int i = 0; i < 300; i++) begin
      eval   = ($urandom_range(0, 7) != 0);
      f_one  = {$urandom, $urandom};
      f_zero = {$urandom, $urandom};
      thr_we = ($urandom_range(0, 5) == 0);
      thr_wd = $urandom_range(0, 255);
      step("R6 random");
    end
    done = 1;
    summary();
    $finish;
  end
endmodule